// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a fast source clock using two cascaded ratios. The first is a power-of-two prescale and the second is a linear divide of 1 to 16. The overall division ratio is the product of the two. The output is a registered waveform with a fixed phase. Each period opens with its high phase, and the high phase lasts the larger half of the period.

Reconfiguration is glitch-free. When the two codes select a ratio different from the one currently running, the stable flag drops at once. The period already under way finishes at full width. The new ratio is loaded at that period's end, and the output stays low for one complete period of the new ratio. The output then resumes and the stable flag returns. The enable input stops the output right away. When the enable returns, the output restarts only at a period boundary, so the first pulse after an enable is never short.

Top module: `sdclk_divider`

## Requirements
- R1: The prescale code maps to a prescale value as follows. Code 0 gives 1. Any other code gives 2^(k+1), where k is the position of its highest set bit. So 0x01 gives 2, 0x03 gives 4 and 0x80 gives 256.
- R2: A divisor code c gives a linear divide of c+1, so codes 0 to 15 give 1 to 16.
- R3: Let N be the prescale value times the divide. The card clock repeats every N source cycles. It is high for the first N - floor(N/2) cycles of each period and low for the rest. A product of 1 runs as N = 2.
- R4: During reset, the card clock and the stable flag are both low. After reset is released, the stable flag rises once the first full period has elapsed. With the reset ratio of 2, that is two source cycles.
- R5: The stable flag is low in the cycle after the codes select a ratio that differs from the active one.
- R6: A new ratio takes effect only at the end of the current period. A high phase already in progress completes at its full width.
- R7: From the end of the old period until the stable flag returns, the card clock stays low. The stable flag returns, and the card clock goes high, after exactly one full period of the new ratio.
- R8: When the enable is low, the card clock is low from the next cycle onward. The stable flag does not change.
- R9: After the enable rises, the card clock restarts at a period boundary. Its first high phase has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale_sel | input | 8 | Prescale code (PRE_W bits) |
| divisor_sel | input | 4 | Linear divisor code, divide minus one (DIV_W bits) |
| card_clk_en | input | 1 | Card clock enable |
| card_clk | output | 1 | Divided card clock |
| card_clk_stable | output | 1 | High when the running ratio matches the codes and has settled |

## Verification
The bench builds the block with its default widths: an 8-bit prescale code and a 4-bit divisor code. These widths bring every ratio from the clamped minimum of 2 up to the full 256 x 16 = 4096 within reach. A run of the largest ratio fits easily inside the cycle budget. They also cover an odd ratio of 3, where the two phases differ in length, and a prescale code with several bits set, which exercises the highest-bit rule. The reconfiguration case switches from a ratio of 20 to a ratio of 6 partway through a high phase. That case pins down the full-width finish, the exact 16-cycle low window, and the restart.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int unsigned SDCLK_PRE_W_DEF = 8;
    localparam int unsigned SDCLK_DIV_W_DEF = 4;
    localparam int unsigned SDCLK_RESET_RATIO = 2;
endpackage

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec #(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned DIV_W = 4,
    localparam int unsigned RAT_W = PRE_W + DIV_W + 1,
    localparam int unsigned SH_W  = $clog2(PRE_W + 1)
) (
    input  logic [PRE_W-1:0] pre_code,
    input  logic [DIV_W-1:0] div_code,
    output logic [RAT_W-1:0] ratio
);
    logic [SH_W-1:0]  shift;
    logic [RAT_W-1:0] linear;
    logic [RAT_W-1:0] product;

    // highest set bit of the prescale code selects the power of two
    always_comb begin
        shift = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (pre_code[i]) shift = SH_W'(i + 1);
        end
    end

    always_comb begin
        linear  = RAT_W'(div_code) + RAT_W'(1);
        product = linear << shift;
        ratio   = (product == RAT_W'(1)) ? RAT_W'(2) : product;
    end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
    parameter int unsigned RAT_W = 13,
    parameter int unsigned RESET_RATIO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAT_W-1:0] req_ratio,
    input  logic             gate_nxt,
    output logic             boundary,
    output logic [RAT_W-1:0] active_ratio,
    output logic             clk_out
);
    typedef struct packed {
        logic [RAT_W-1:0] ratio;
        logic [RAT_W-1:0] cnt;
        logic             out;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic [RAT_W-1:0] hi_d;

    assign boundary     = (st_q.cnt == st_q.ratio - RAT_W'(1));
    assign active_ratio = st_q.ratio;
    assign clk_out      = st_q.out;

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.cnt = '0;
            if (req_ratio != st_q.ratio) st_d.ratio = req_ratio;
        end else begin
            st_d.cnt = st_q.cnt + RAT_W'(1);
        end
        hi_d     = st_d.ratio - (st_d.ratio >> 1);
        st_d.out = gate_nxt && (st_d.cnt < hi_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ratio <= RAT_W'(RESET_RATIO);
            st_q.cnt   <= '0;
            st_q.out   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: every rising edge opens a period
    a_r3_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.out) |-> (st_q.cnt == '0));
    // R3: phase counter stays inside the active period
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.ratio);
    // R6: the active ratio only moves at a period end
    a_r6_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(st_q.ratio));
endmodule

// File: rtl/sdclk_settle_ctl.sv
module sdclk_settle_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic card_en,
    input  logic boundary,
    input  logic change,
    output logic gate_nxt,
    output logic stable
);
    typedef struct packed {
        logic stable;
        logic gate;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (change)        st_d.stable = 1'b0;
        else if (boundary) st_d.stable = 1'b1;
        if (!card_en)      st_d.gate = 1'b0;
        else if (boundary) st_d.gate = !change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stable <= 1'b0;
            st_q.gate   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_nxt = st_d.gate;
    assign stable   = st_q.stable;

    // R5: a pending ratio change clears the stable flag next cycle
    a_r5_change_drops_stable: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> !st_q.stable);
    // R7: the stable flag returns only at a period end
    a_r7_settle_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stable) |-> $past(boundary));
    // R8: gate is closed the cycle after enable is low
    a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |=> !st_q.gate);
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
    parameter int unsigned PRE_W = sdclk_pkg::SDCLK_PRE_W_DEF,
    parameter int unsigned DIV_W = sdclk_pkg::SDCLK_DIV_W_DEF,
    localparam int unsigned RAT_W = PRE_W + DIV_W + 1
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale_sel,
    input  logic [DIV_W-1:0] divisor_sel,
    input  logic             card_clk_en,
    output logic             card_clk,
    output logic             card_clk_stable
);
    logic [RAT_W-1:0] req_ratio;
    logic [RAT_W-1:0] active_ratio;
    logic             boundary;
    logic             gate_nxt;
    logic             change;

    sdclk_ratio_dec #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_dec (
        .pre_code (prescale_sel),
        .div_code (divisor_sel),
        .ratio    (req_ratio)
    );

    assign change = (req_ratio != active_ratio);

    sdclk_phase_gen #(.RAT_W(RAT_W), .RESET_RATIO(sdclk_pkg::SDCLK_RESET_RATIO)) u_phase (
        .clk          (clk_src),
        .rst_n        (rst_n),
        .req_ratio    (req_ratio),
        .gate_nxt     (gate_nxt),
        .boundary     (boundary),
        .active_ratio (active_ratio),
        .clk_out      (card_clk)
    );

    sdclk_settle_ctl u_ctl (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .card_en  (card_clk_en),
        .boundary (boundary),
        .change   (change),
        .gate_nxt (gate_nxt),
        .stable   (card_clk_stable)
    );

    // R8: output held low while enable is low
    a_r8_enable_holds_low: assert property (@(posedge clk_src) disable iff (!rst_n)
        !card_clk_en |=> !card_clk);
    // R9: output only starts after enable was present
    a_r9_start_needs_enable: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(card_clk) |-> $past(card_clk_en));
endmodule

// File: tb/test_sdclk_divider.sv
module test_sdclk_divider;
    logic       clk_src = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prescale_sel = 8'h00;
    logic [3:0] divisor_sel = 4'h1;
    logic       card_clk_en = 1'b1;
    logic       card_clk;
    logic       card_clk_stable;

    int checks = 0;
    int errors = 0;

    int    q_per[$];
    int    q_hi[$];
    string q_tag[$];
    bit    meas = 1'b0;
    int    mcyc = 0;
    int    mhi = 0;
    logic  prev_clk = 1'b0;
    int    ep, eh;
    string et;

    always #5 clk_src = ~clk_src;

    sdclk_divider i_sdclk_divider (
        .clk_src         (clk_src),
        .rst_n           (rst_n),
        .prescale_sel    (prescale_sel),
        .divisor_sel     (divisor_sel),
        .card_clk_en     (card_clk_en),
        .card_clk        (card_clk),
        .card_clk_stable (card_clk_stable)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ratio(input int pre, input int dv);
        int p = 1;
        for (int i = 0; i < 8; i++) if (pre[i]) p = 2 << i;
        exp_ratio = p * (dv + 1);
        if (exp_ratio == 1) exp_ratio = 2;
    endfunction

    // monitor: measures each period from rise to rise and scores it
    always @(negedge clk_src) begin
        if (card_clk && !prev_clk) begin
            if (meas) begin
                ep = q_per.pop_front();
                eh = q_hi.pop_front();
                et = q_tag.pop_front();
                check(mcyc == ep, {et, " period"}, mcyc, ep);
                check(mhi == eh, {et, " high phase"}, mhi, eh);
            end
            meas = (q_per.size() != 0);
            mcyc = 0;
            mhi = 0;
        end
        if (meas) begin
            mcyc++;
            if (card_clk) mhi++;
        end
        prev_clk = card_clk;
    end

    task automatic push_exp(input int n, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) begin
            q_per.push_back(n);
            q_hi.push_back(n - n / 2);
            q_tag.push_back(tag);
        end
    endtask

    task automatic drain();
        while (q_per.size() != 0 || meas) @(negedge clk_src);
    endtask

    task automatic wait_stable();
        while (!card_clk_stable) @(negedge clk_src);
    endtask

    task automatic wait_rise();
        logic p;
        p = card_clk;
        forever begin
            @(negedge clk_src);
            if (card_clk && !p) break;
            p = card_clk;
        end
    endtask

    task automatic run_cfg(input int pre, input int dv, input int nper, input string tag);
        int n;
        n = exp_ratio(pre, dv);
        @(negedge clk_src);
        prescale_sel = 8'(pre);
        divisor_sel = 4'(dv);
        @(negedge clk_src);
        wait_stable();
        push_exp(n, nper, tag);
        drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk_src);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lowc, hiw, hc, k, waitc;
        bit any_hi, stab_ok;

        repeat (3) @(negedge clk_src);
        check(card_clk == 1'b0, "R4 clk in reset", int'(card_clk), 0);
        check(card_clk_stable == 1'b0, "R4 stable in reset", int'(card_clk_stable), 0);
        rst_n = 1'b1;
        waitc = 0;
        @(negedge clk_src);
        while (!card_clk_stable && waitc < 20) begin
            waitc++;
            @(negedge clk_src);
        end
        check(waitc == 1, "R4 stable after first period", waitc, 1);
        push_exp(2, 3, "R3");
        drain();

        run_cfg(8'h00, 0, 3, "R3");
        run_cfg(8'h00, 2, 3, "R3");
        run_cfg(8'h00, 15, 2, "R2");
        run_cfg(8'h03, 1, 2, "R1");
        run_cfg(8'h10, 2, 2, "R1");
        run_cfg(8'h80, 0, 2, "R1");
        run_cfg(8'h80, 15, 1, "R2");

        // reconfiguration mid high phase: 20 -> 6
        run_cfg(8'h02, 4, 2, "R2");
        wait_rise();
        hc = 1;
        k = 0;
        forever begin
            @(negedge clk_src);
            k++;
            if (k == 3) begin
                prescale_sel = 8'h00;
                divisor_sel = 4'd5;
            end
            if (k == 4) check(card_clk_stable == 1'b0, "R5 stable drop", int'(card_clk_stable), 0);
            if (card_clk) hc++;
            else break;
        end
        check(hc == 10, "R6 full high phase", hc, 10);
        lowc = 0;
        hiw = 0;
        while (!card_clk_stable && lowc < 100) begin
            if (card_clk) hiw++;
            lowc++;
            @(negedge clk_src);
        end
        check(hiw == 0, "R7 low while settling", hiw, 0);
        check(lowc == 16, "R7 settle length", lowc, 16);
        check(card_clk == 1'b1, "R7 restart high", int'(card_clk), 1);
        push_exp(6, 2, "R7");
        drain();

        // enable behaviour at ratio 8
        run_cfg(8'h01, 3, 1, "R3");
        wait_rise();
        card_clk_en = 1'b0;
        @(negedge clk_src);
        check(card_clk == 1'b0, "R8 immediate low", int'(card_clk), 0);
        any_hi = 1'b0;
        stab_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_src);
            if (card_clk) any_hi = 1'b1;
            if (!card_clk_stable) stab_ok = 1'b0;
        end
        check(any_hi == 1'b0, "R8 held low", int'(any_hi), 0);
        check(stab_ok == 1'b1, "R8 stable unaffected", int'(stab_ok), 1);
        push_exp(8, 2, "R9");
        card_clk_en = 1'b1;
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule